// File: doc/BRIEF.md
# Prioritised Interrupt Selector with Masking

This block decides, once per clock, which interrupt the processor should take next. It looks at a vector of programmable sources, each with an enable bit, a pending bit and a priority value, together with two fixed-priority sources: a non-maskable request and a hard-fault request. These two rank above every programmable level, and the non-maskable request ranks above the hard fault. Among the eligible programmable sources the smallest priority value wins, and a tie goes to the lowest source number.

Three masking controls narrow the eligible set. A global mask blocks every programmable source. A fault mask blocks the hard fault as well, so only the non-maskable request remains; it is set by a request pulse and clears itself when the guarded handler returns. A nonzero priority threshold blocks every programmable source whose priority value is not strictly below it. Priority values are MSB-aligned, and only the upper `IMPL_BITS` bits are implemented. A split code divides each priority into a group part and a subpriority part. Only the group part is compared against the currently running priority to decide preemption.

The decision is computed combinationally and registered, so an input change shows on the outputs one clock later. Stacking, vector fetch and register access lie outside this block.

Top module: `irq_selector`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are `take_o`=0, `preempt_o`=0 and `sel_id_o`=0, and the fault mask is cleared.
- R2: Identifier encoding: 0 is the non-maskable request, 1 is the hard fault, and programmable source n is n+2. The non-maskable request wins over the hard fault, and the hard fault wins over every programmable source.
- R3: A programmable source is a candidate when it is both enabled and pending. The candidate with the smallest effective priority wins, and equal values go to the lowest source number. The effective priority is the value with its low `PRIO_W-IMPL_BITS` bits forced to zero.
- R4: When `primask_i` is 1, no programmable source is taken. The non-maskable request and the hard fault are still taken.
- R5: A fault mask is set by a `fmask_set_i` pulse and cleared by a `fmask_ret_i` pulse, with clear winning when both are high. Either change takes effect from the next cycle's decision. While the fault mask is set, the hard fault and all programmable sources are blocked, and the non-maskable request is still taken.
- R6: The effective threshold is `basepri_i` with its unimplemented low bits forced to zero. When it is zero, nothing is masked. When it is nonzero, a programmable source is blocked unless its effective priority is strictly less than the threshold.
- R7: The group part of a priority is made of the bits above position `split_i`: code c keeps bits [PRIO_W-1:c+1], so code PRIO_W-1 keeps no bits. `preempt_o` is 1 only when `take_o` is 1 and one of these holds: `run_valid_i` is 0, the winner is a fixed source, or the winner's group part is strictly less than the group part of the effective running priority.
- R8: When no source is eligible, `take_o`=0, `preempt_o`=0 and `sel_id_o`=0.
- R9: The outputs after a clock edge reflect the inputs and fault-mask state sampled at that edge, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_en_i | input | NUM_IRQ | Per-source enable |
| irq_pend_i | input | NUM_IRQ | Per-source pending |
| irq_prio_i | input | NUM_IRQ*PRIO_W | Priority of source n in bits [n*PRIO_W +: PRIO_W] |
| nmi_req_i | input | 1 | Non-maskable request |
| hf_req_i | input | 1 | Hard-fault request |
| primask_i | input | 1 | Global mask of programmable sources |
| fmask_set_i | input | 1 | Sets the fault mask |
| fmask_ret_i | input | 1 | Handler return; clears the fault mask |
| basepri_i | input | PRIO_W | Priority threshold, zero disables it |
| split_i | input | $clog2(PRIO_W) | Group/subpriority split code |
| run_valid_i | input | 1 | A handler is currently running |
| run_prio_i | input | PRIO_W | Priority of the running handler |
| sel_id_o | output | $clog2(NUM_IRQ+2) | Selected identifier |
| take_o | output | 1 | An eligible source exists |
| preempt_o | output | 1 | The winner preempts the running handler |

## Verification
The bench builds the block with six programmable sources, which is not a power of two, and with four implemented bits in an 8-bit priority. These values make the ignored low priority bits and the ignored low threshold bits observable. For example, a threshold of 0x05 acts as zero, and priorities 0x4F and 0x40 tie. The split code runs from 3, where all four implemented bits form the group, to 7, where there is no group part at all. This covers the cases where the subpriority orders the winner but does not allow preemption.

// File: rtl/irqsel_pkg.sv
// Package: shared identifier constants for the interrupt selector.
// Assumes identifiers 0 and 1 are reserved for the fixed sources.
package irqsel_pkg;
    localparam int FIXED_SRCS = 2;   // number of fixed-priority sources
    localparam int ID_NMI     = 0;   // non-maskable request identifier
    localparam int ID_HFAULT  = 1;   // hard-fault identifier
endpackage

// File: rtl/irqsel_gate.sv
// Module: per-source eligibility gate.
// Applies enable, pending, global mask, fault mask and threshold to each
// programmable source, and strips unimplemented low priority bits.
// Assumes priorities are MSB-aligned with IMPL_BITS implemented bits.
module irqsel_gate #(
    parameter int NUM_IRQ   = 8,
    parameter int PRIO_W    = 8,
    parameter int IMPL_BITS = 4
) (
    input  logic [NUM_IRQ-1:0]        en_i,
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    input  logic                      primask_i,
    input  logic                      fmask_i,
    input  logic [PRIO_W-1:0]         thr_i,
    output logic [NUM_IRQ-1:0]        elig_o,
    output logic [NUM_IRQ*PRIO_W-1:0] prio_eff_o
);
    localparam int          DROP_BITS = PRIO_W - IMPL_BITS;
    localparam logic [PRIO_W-1:0] IMPL_MASK = {{IMPL_BITS{1'b1}}, {DROP_BITS{1'b0}}};

    logic [PRIO_W-1:0] thr_eff;
    logic              thr_off;
    logic              blocked_all;

    // Effective threshold and source-independent block conditions.
    assign thr_eff     = thr_i & IMPL_MASK;
    assign thr_off     = (thr_eff == '0);
    assign blocked_all = primask_i | fmask_i;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
        logic [PRIO_W-1:0] p_eff;
        logic              under_thr;
        // Per-source effective priority and threshold test.
        assign p_eff     = prio_i[g*PRIO_W +: PRIO_W] & IMPL_MASK;
        assign under_thr = thr_off | (p_eff < thr_eff);
        assign elig_o[g] = en_i[g] & pend_i[g] & ~blocked_all & under_thr;
        assign prio_eff_o[g*PRIO_W +: PRIO_W] = p_eff;
    end
endmodule

// File: rtl/irqsel_pick.sv
// Module: picks the most urgent eligible programmable source.
// Smallest priority value wins; on a tie the lowest index is kept because
// a later source must be strictly smaller to replace the current best.
module irqsel_pick #(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 8,
    parameter int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_IRQ-1:0]        elig_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    output logic                      found_o,
    output logic [IDX_W-1:0]          idx_o,
    output logic [PRIO_W-1:0]         prio_o
);
    // Linear scan over the sources in index order.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig_i[i] && (!found_o || (prio_i[i*PRIO_W +: PRIO_W] < prio_o))) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                prio_o  = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irqsel_fmask.sv
// Module: fault-mask state bit.
// Set by a request pulse, cleared by handler return; return wins.
module irqsel_fmask (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ret_i,
    output logic fmask_o
);
    // Hold the fault mask across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)     fmask_o <= 1'b0;
        else if (ret_i) fmask_o <= 1'b0;
        else if (set_i) fmask_o <= 1'b1;
    end
endmodule

// File: rtl/irq_selector.sv
// Module: top of the prioritised interrupt selector.
// Ranks the non-maskable request, then the hard fault, then the programmable
// sources. It applies the masks and decides preemption on the group part
// only. Outputs are registered, so there is one cycle of latency.
// Assumes the running handler, when valid, has a programmable priority.
module irq_selector #(
    parameter int NUM_IRQ   = 8,
    parameter int PRIO_W    = 8,
    parameter int IMPL_BITS = 4,
    parameter int SPLIT_W   = $clog2(PRIO_W),
    parameter int ID_W      = $clog2(NUM_IRQ + irqsel_pkg::FIXED_SRCS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        irq_en_i,
    input  logic [NUM_IRQ-1:0]        irq_pend_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio_i,
    input  logic                      nmi_req_i,
    input  logic                      hf_req_i,
    input  logic                      primask_i,
    input  logic                      fmask_set_i,
    input  logic                      fmask_ret_i,
    input  logic [PRIO_W-1:0]         basepri_i,
    input  logic [SPLIT_W-1:0]        split_i,
    input  logic                      run_valid_i,
    input  logic [PRIO_W-1:0]         run_prio_i,
    output logic [ID_W-1:0]           sel_id_o,
    output logic                      take_o,
    output logic                      preempt_o
);
    import irqsel_pkg::*;

    localparam int IDX_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam int DROP_BITS = PRIO_W - IMPL_BITS;
    localparam logic [PRIO_W-1:0] IMPL_MASK = {{IMPL_BITS{1'b1}}, {DROP_BITS{1'b0}}};

    logic                      fmask_q;
    logic [NUM_IRQ-1:0]        elig;
    logic [NUM_IRQ*PRIO_W-1:0] prio_eff;
    logic                      found;
    logic [IDX_W-1:0]          win_idx;
    logic [PRIO_W-1:0]         win_prio;
    logic [PRIO_W-1:0]         grp_mask;
    logic [ID_W-1:0]           id_d;
    logic                      take_d;
    logic                      fixed_d;
    logic                      preempt_d;

    irqsel_fmask u_fmask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (fmask_set_i),
        .ret_i   (fmask_ret_i),
        .fmask_o (fmask_q)
    );

    irqsel_gate #(
        .NUM_IRQ   (NUM_IRQ),
        .PRIO_W    (PRIO_W),
        .IMPL_BITS (IMPL_BITS)
    ) u_gate (
        .en_i       (irq_en_i),
        .pend_i     (irq_pend_i),
        .prio_i     (irq_prio_i),
        .primask_i  (primask_i),
        .fmask_i    (fmask_q),
        .thr_i      (basepri_i),
        .elig_o     (elig),
        .prio_eff_o (prio_eff)
    );

    irqsel_pick #(
        .NUM_IRQ (NUM_IRQ),
        .PRIO_W  (PRIO_W),
        .IDX_W   (IDX_W)
    ) u_pick (
        .elig_i  (elig),
        .prio_i  (prio_eff),
        .found_o (found),
        .idx_o   (win_idx),
        .prio_o  (win_prio)
    );

    // Group-part mask: bit b belongs to the group when it lies above the split.
    for (genvar b = 0; b < PRIO_W; b++) begin : g_grp
        assign grp_mask[b] = (b > int'(split_i));
    end

    // Fixed sources first, then the programmable winner.
    always_comb begin
        id_d    = '0;
        take_d  = 1'b0;
        fixed_d = 1'b0;
        if (nmi_req_i) begin
            id_d    = ID_W'(ID_NMI);
            take_d  = 1'b1;
            fixed_d = 1'b1;
        end else if (hf_req_i && !fmask_q) begin
            id_d    = ID_W'(ID_HFAULT);
            take_d  = 1'b1;
            fixed_d = 1'b1;
        end else if (found) begin
            id_d   = ID_W'(win_idx) + ID_W'(FIXED_SRCS);
            take_d = 1'b1;
        end
    end

    // Preemption compares the group parts only.
    always_comb begin
        preempt_d = take_d && (!run_valid_i || fixed_d ||
                    ((win_prio & grp_mask) < (run_prio_i & IMPL_MASK & grp_mask)));
    end

    // Register the decision once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_id_o  <= '0;
            take_o    <= 1'b0;
            preempt_o <= 1'b0;
        end else begin
            sel_id_o  <= id_d;
            take_o    <= take_d;
            preempt_o <= preempt_d;
        end
    end

    // ---------------- assertions ----------------
    assert_preempt_needs_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_o |-> take_o);

    assert_idle_outputs_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (sel_id_o == '0) && !preempt_o);

    assert_nmi_taken_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req_i |=> take_o && (sel_id_o == ID_W'(ID_NMI)) && preempt_o);

    assert_primask_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (primask_i && !nmi_req_i && !hf_req_i) |=> !take_o);

    assert_fmask_blocks_hf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fmask_q && !nmi_req_i) |=> !take_o);

    assert_fmask_return_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fmask_ret_i |=> !fmask_q);
endmodule

// File: tb/irq_selector_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock.
module irq_selector_bench;
    localparam int N   = 6;
    localparam int PW  = 8;
    localparam int IB  = 4;
    localparam int SW  = 3;
    localparam int IDW = $clog2(N + 2);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    en = '0, pend = '0;
    logic [N*PW-1:0] prio = '0;
    logic            nmi = 1'b0, hf = 1'b0, pm = 1'b0, fset = 1'b0, fret = 1'b0;
    logic [PW-1:0]   bp = '0, rprio = '0;
    logic [SW-1:0]   split = 3'd3;
    logic            rvalid = 1'b0;
    logic [IDW-1:0]  sel_id;
    logic            take, preempt;

    int checks = 0, fails = 0;
    int fm_m = 0;
    bit done = 0;

    irq_selector #(.NUM_IRQ(N), .PRIO_W(PW), .IMPL_BITS(IB)) u_irq_selector (
        .clk(clk), .rst_n(rst_n), .irq_en_i(en), .irq_pend_i(pend), .irq_prio_i(prio),
        .nmi_req_i(nmi), .hf_req_i(hf), .primask_i(pm), .fmask_set_i(fset),
        .fmask_ret_i(fret), .basepri_i(bp), .split_i(split), .run_valid_i(rvalid),
        .run_prio_i(rprio), .sel_id_o(sel_id), .take_o(take), .preempt_o(preempt));

    always #2.5 clk = ~clk;

    task automatic set_p(int i, int v);
        prio[i*PW +: PW] = PW'(v);
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock: model the decision from current inputs, then compare after the edge.
    task automatic step(string tag);
        int eid = 0, etake = 0, epre = 0, best = -1, bprio = 0, fixed = 0;
        int thr, gm = 0, rp, p;
        if (rst_n) begin
            thr = bp & 8'hF0;
            for (int b = 0; b < PW; b++) if (b > split) gm |= (1 << b);
            if (nmi) begin eid = 0; etake = 1; fixed = 1; end
            else if (hf && fm_m == 0) begin eid = 1; etake = 1; fixed = 1; end
            else if (!pm && fm_m == 0) begin
                for (int i = 0; i < N; i++) begin
                    p = prio[i*PW +: PW] & 8'hF0;
                    if (en[i] && pend[i] && (thr == 0 || p < thr) && (best < 0 || p < bprio)) begin
                        best = i; bprio = p;
                    end
                end
                if (best >= 0) begin eid = best + 2; etake = 1; end
            end
            rp = rprio & 8'hF0 & gm;
            if (etake && (!rvalid || fixed || ((bprio & gm) < rp))) epre = 1;
            if (fret) fm_m = 0; else if (fset) fm_m = 1;
        end else fm_m = 0;
        @(posedge clk);
        #1;
        chk(tag, "take_o", int'(take), etake);
        chk(tag, "sel_id_o", int'(sel_id), eid);
        chk(tag, "preempt_o", int'(preempt), epre);
    endtask

    task automatic clear_all();
        en = '0; pend = '0; prio = '0; nmi = 0; hf = 0; pm = 0; fset = 0; fret = 0;
        bp = '0; rvalid = 0; rprio = '0; split = 3'd3;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, even with requests present
        nmi = 1; en = '1; pend = '1;
        step("R1"); step("R1");
        rst_n = 1; clear_all();
        step("R8");                                   // R8: nothing eligible

        // R3: smallest value wins
        en = '1; set_p(2, 8'h30); set_p(4, 8'h20); pend = 6'b010100;
        step("R3");
        // R3: tie goes to lowest number
        pend = 6'b001010; set_p(1, 8'h40); set_p(3, 8'h40);
        step("R3");
        // R3: unimplemented low bits ignored (0x4F ties with 0x40)
        pend = 6'b000011; set_p(0, 8'h4F); set_p(1, 8'h40);
        step("R3");
        // R3: disabled source not taken
        en = 6'b111110; step("R3"); en = '1;

        // R2: fixed ordering
        nmi = 1; hf = 1; step("R2");
        nmi = 0; step("R2");
        hf = 0;

        // R4: global mask
        pm = 1; step("R4");
        hf = 1; step("R4");
        hf = 0; pm = 0;

        // R5: fault mask
        fset = 1; step("R5");                         // set this cycle, not yet active
        fset = 0; hf = 1; step("R5");                 // hard fault blocked
        hf = 0; step("R5");                           // programmable blocked
        nmi = 1; step("R5"); nmi = 0;                 // non-maskable still taken
        fret = 1; hf = 1; step("R5");                 // return this cycle
        fret = 0; step("R5");                         // hard fault taken again
        fset = 1; fret = 1; step("R5");               // clear wins
        fset = 0; fret = 0; step("R5");
        hf = 0;

        // R6: threshold
        clear_all(); en = '1;
        set_p(0, 8'h40); set_p(1, 8'h50); pend = 6'b000011;
        bp = 8'h50; step("R6");
        pend = 6'b000010; step("R6");                 // 0x50 held off
        bp = 8'h05; step("R6");                       // effective zero
        bp = 8'h00; step("R6");

        // R7: preemption on group part
        clear_all(); en = '1; rvalid = 1; rprio = 8'h40; split = 3'd4;
        pend = 6'b000100; set_p(2, 8'h20); step("R7");
        set_p(2, 8'h50); step("R7");                  // same group 0x40
        set_p(2, 8'h30); step("R7");                  // group 0x20 < 0x40
        split = 3'd7; step("R7");                     // no group bits
        split = 3'd3; step("R7");
        rvalid = 0; set_p(2, 8'hE0); step("R7");
        rvalid = 1; hf = 1; step("R7"); hf = 0;

        // R9: one-cycle latency under varied stimulus
        for (int k = 0; k < 400; k++) begin
            en = N'($urandom); pend = N'($urandom);
            for (int i = 0; i < N; i++) set_p(i, int'($urandom_range(0, 255)));
            nmi = ($urandom_range(0, 15) == 0); hf = ($urandom_range(0, 7) == 0);
            pm = ($urandom_range(0, 5) == 0);
            fset = ($urandom_range(0, 9) == 0); fret = ($urandom_range(0, 7) == 0);
            bp = ($urandom_range(0, 2) == 0) ? PW'($urandom) : '0;
            split = SW'($urandom_range(3, 7));
            rvalid = $urandom_range(0, 1) == 1; rprio = PW'($urandom);
            step("R9");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule